// File: doc/BRIEF.md
# NAND flash card interface controller

This block sits between a host's memory-mapped bus and the control pins of a removable NAND flash card that is reached through a 16-byte window. Byte offset bits of each window access choose what the card sees: one bit raises the command-latch enable, another raises the address-latch enable, and with both low the access moves data. The two latch enables are captured when an access begins and are then held. Cards that reject latch enables changing between byte cycles therefore see steady levels for the whole access.

Read and write strobes reach the card only during window accesses. Reads are blocked in the upper half of the window. A host that always reads a location before writing it can then write commands, addresses and data at offsets 8 to 15 with no stray read pulse. Chip enable comes from a control bit and is not tied to each access, because deasserting it aborts card commands. Card data uses the upper byte of the host's 16-bit bus. The card's ready, presence and write-protect sense lines are synchronised and returned as a status byte. A strap can force the card's write-protect pin from the sense line.

Top module: `nand_card_if`

## Requirements
- R1: In the first clock cycle in which `sel_i` is high after a cycle in which it was low, `card_cle_o` takes byte offset bit 2 (`addr_i[2]`) and `card_ale_o` takes offset bit 1 (`addr_i[1]`). Both values appear one clock later.
- R2: Outside such a first cycle, `card_cle_o` and `card_ale_o` keep their values, even while the offset changes during an access. Both are 0 after reset, which selects a data access.
- R3: `card_ce_no` is the inverse of `ce_en_i`, delayed by one clock. It is 1 (standby) after reset and does not depend on `sel_i`.
- R4: `card_we_no` is 0 one clock after a cycle with `sel_i` and `wr_i` both high. It is 1 at all other times, including after reset.
- R5: `card_re_no` is 0 one clock after a cycle with `sel_i` and `rd_i` high and offset bit 3 (`addr_i[3]`) low, which is offsets 0 to 7. For offsets 8 to 15, or with `sel_i` low, it stays 1.
- R6: `card_d_oe_o` is 1 one clock after a window write cycle, with `card_d_o` equal to that cycle's `wdata_i`. At all other times, including after reset, it is 0 (input).
- R7: `rdata_o` equals `{card_d_i, 8'h00}` with no clock delay, so card data sits in the upper byte.
- R8: `status_o` bit 5 is ready (1 = ready, 0 = busy), bit 6 is card present (1 = inserted) and bit 7 is write-protect sense (0 = protected). The other bits are 0. All three follow their inputs after `SYNC_STAGES` clocks and are 0 after reset.
- R9: With `enforce_i` high, `card_wp_no` equals the synchronised write-protect sense (the value shown in `status_o[7]`). With `enforce_i` low, it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Card window select for the current cycle |
| rd_i | input | 1 | Host read strobe |
| wr_i | input | 1 | Host write strobe |
| addr_i | input | 3 | Window byte offset bits 3..1 |
| wdata_i | input | 8 | Upper byte of host write data |
| rdata_o | output | 16 | Host read data, card byte in upper half |
| ce_en_i | input | 1 | Card enable control bit |
| enforce_i | input | 1 | Hardware write-protect enforce strap |
| card_cle_o | output | 1 | Card command latch enable |
| card_ale_o | output | 1 | Card address latch enable |
| card_ce_no | output | 1 | Card chip enable, active low |
| card_we_no | output | 1 | Card write strobe, active low |
| card_re_no | output | 1 | Card read strobe, active low |
| card_d_o | output | 8 | Card data out |
| card_d_oe_o | output | 1 | Card data drive enable |
| card_d_i | input | 8 | Card data in |
| card_rb_i | input | 1 | Card ready/busy, low = busy |
| card_present_i | input | 1 | Card present sense, high = inserted |
| card_wp_sense_i | input | 1 | Write-protect sense, low = protected |
| card_wp_no | output | 1 | Card write-protect pin, active low |
| status_o | output | 8 | Status byte |

## Verification
Random window accesses with mixed reads and writes, random offsets and frequent gaps in the select line test latch capture against latch holding. They also show whether a strobe follows the select, the direction and the offset mask. Directed accesses in which the offset changes while the select stays high show whether the latch enables follow the address or only the access start. A read at offset 8 against one at offset 7 shows whether the mask is placed at the half-window boundary. Random status and strap combinations, held past the synchroniser delay, test each status bit position and the enforce mux in both strap states.

// File: rtl/nand_if_pkg.sv
package nand_if_pkg;
  localparam int unsigned STAT_W    = 8;
  localparam int unsigned STAT_RDY  = 5;
  localparam int unsigned STAT_PRES = 6;
  localparam int unsigned STAT_WP   = 7;
  localparam int unsigned N_SENSE   = 3;

  typedef struct packed {
    logic cle;
    logic ale;
  } latch_t;
endpackage

// File: rtl/nand_latch_ctrl.sv
module nand_latch_ctrl
  import nand_if_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sel_i,
  input  logic   cle_bit_i,
  input  logic   ale_bit_i,
  output latch_t latch_o
);
  logic   sel_q;
  logic   start;
  latch_t latch_q;

  assign start = sel_i & ~sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      latch_q <= '0;
    end else begin
      sel_q <= sel_i;
      // capture only at access start; hold across byte cycles
      if (start) begin
        latch_q.cle <= cle_bit_i;
        latch_q.ale <= ale_bit_i;
      end
    end
  end

  assign latch_o = latch_q;
endmodule

// File: rtl/nand_strobe_gate.sv
module nand_strobe_gate #(
  parameter int unsigned BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic          hi_half_i,
  input  logic [BW-1:0] wdata_i,
  output logic          we_no,
  output logic          re_no,
  output logic [BW-1:0] d_o,
  output logic          d_oe_o
);
  logic wr_hit;
  logic rd_hit;

  assign wr_hit = sel_i & wr_i;
  // upper half of window is write-only
  assign rd_hit = sel_i & rd_i & ~hi_half_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_no  <= 1'b1;
      re_no  <= 1'b1;
      d_oe_o <= 1'b0;
      d_o    <= '0;
    end else begin
      we_no  <= ~wr_hit;
      re_no  <= ~rd_hit;
      d_oe_o <= wr_hit;
      if (wr_hit) d_o <= wdata_i;
    end
  end
endmodule

// File: rtl/nand_status_sync.sv
module nand_status_sync
  import nand_if_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rb_i,
  input  logic              present_i,
  input  logic              wp_sense_i,
  input  logic              enforce_i,
  output logic [STAT_W-1:0] status_o,
  output logic              wp_no
);
  logic [N_SENSE-1:0] raw;
  logic [N_SENSE-1:0] synced;

  assign raw = {wp_sense_i, present_i, rb_i};

  for (genvar g = 0; g < N_SENSE; g++) begin : g_sync
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pipe_q <= '0;
      end else begin
        pipe_q[0] <= raw[g];
        for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
      end
    end
    assign synced[g] = pipe_q[STAGES-1];
  end

  always_comb begin
    status_o            = '0;
    status_o[STAT_RDY]  = synced[0];
    status_o[STAT_PRES] = synced[1];
    status_o[STAT_WP]   = synced[2];
  end

  assign wp_no = enforce_i ? synced[2] : 1'b1;
endmodule

// File: rtl/nand_card_if.sv
module nand_card_if
  import nand_if_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CLE_BIT     = 2,
  parameter int unsigned ALE_BIT     = 1,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned BW         = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:1] addr_i,
  input  logic [BW-1:0]     wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ce_en_i,
  input  logic              enforce_i,
  output logic              card_cle_o,
  output logic              card_ale_o,
  output logic              card_ce_no,
  output logic              card_we_no,
  output logic              card_re_no,
  output logic [BW-1:0]     card_d_o,
  output logic              card_d_oe_o,
  input  logic [BW-1:0]     card_d_i,
  input  logic              card_rb_i,
  input  logic              card_present_i,
  input  logic              card_wp_sense_i,
  output logic              card_wp_no,
  output logic [STAT_W-1:0] status_o
);
  localparam int unsigned HALF_BIT = ADDR_W - 1;

  latch_t latch;
  logic   ce_nq;

  nand_latch_ctrl u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel_i),
    .cle_bit_i (addr_i[CLE_BIT]),
    .ale_bit_i (addr_i[ALE_BIT]),
    .latch_o   (latch)
  );

  nand_strobe_gate #(.BW(BW)) u_strobe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel_i),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .hi_half_i (addr_i[HALF_BIT]),
    .wdata_i   (wdata_i),
    .we_no     (card_we_no),
    .re_no     (card_re_no),
    .d_o       (card_d_o),
    .d_oe_o    (card_d_oe_o)
  );

  nand_status_sync #(.STAGES(SYNC_STAGES)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rb_i       (card_rb_i),
    .present_i  (card_present_i),
    .wp_sense_i (card_wp_sense_i),
    .enforce_i  (enforce_i),
    .status_o   (status_o),
    .wp_no      (card_wp_no)
  );

  // enable follows the control bit only, never the access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ce_nq <= 1'b1;
    else         ce_nq <= ~ce_en_i;
  end

  assign card_ce_no = ce_nq;
  assign card_cle_o = latch.cle;
  assign card_ale_o = latch.ale;
  assign rdata_o    = {card_d_i, {BW{1'b0}}};
endmodule

// File: rtl/nand_card_if_chk.sv
module nand_card_if_chk #(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned CLE_BIT = 2,
  parameter int unsigned ALE_BIT = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [ADDR_W-1:1] addr_i,
  input logic              ce_en_i,
  input logic              enforce_i,
  input logic              card_cle_o,
  input logic              card_ale_o,
  input logic              card_ce_no,
  input logic              card_we_no,
  input logic              card_re_no,
  input logic              card_d_oe_o,
  input logic              card_wp_no
);
  logic sel_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_d <= 1'b0;
    else         sel_d <= sel_i;
  end

  p_latch_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !sel_d) |=> (card_cle_o == $past(addr_i[CLE_BIT])) &&
                          (card_ale_o == $past(addr_i[ALE_BIT])));

  p_latch_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && !sel_d) |=> $stable(card_cle_o) && $stable(card_ale_o));

  p_ce_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_en_i |=> !card_ce_no);

  p_we_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && wr_i) |=> card_we_no);

  p_re_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && rd_i && addr_i[ADDR_W-1]) |=> card_re_no);

  p_dir_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> !card_d_oe_o);

  p_wp_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enforce_i |-> card_wp_no);
endmodule

bind nand_card_if nand_card_if_chk #(
  .ADDR_W(ADDR_W), .CLE_BIT(CLE_BIT), .ALE_BIT(ALE_BIT)
) u_chk (.*);

// File: tb/nand_card_if_test.sv
module nand_card_if_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        sel_i, rd_i, wr_i;
  logic [3:1]  addr_i;
  logic [7:0]  wdata_i;
  logic [15:0] rdata_o;
  logic        ce_en_i, enforce_i;
  logic        card_cle_o, card_ale_o, card_ce_no, card_we_no, card_re_no;
  logic [7:0]  card_d_o;
  logic        card_d_oe_o;
  logic [7:0]  card_d_i;
  logic        card_rb_i, card_present_i, card_wp_sense_i, card_wp_no;
  logic [7:0]  status_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // expected model
  logic prev_sel, e_cle, e_ale, e_we, e_re, e_oe, e_ce;
  logic [7:0] e_d;

  nand_card_if uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  // drive one cycle of bus inputs at a negedge and advance the model
  task automatic drive(input logic s, input logic r, input logic w,
                       input logic [3:1] a, input logic [7:0] d, input logic ce);
    sel_i = s; rd_i = r; wr_i = w; addr_i = a; wdata_i = d; ce_en_i = ce;
    if (s && !prev_sel) begin
      e_cle = a[2];
      e_ale = a[1];
    end
    prev_sel = s;
    e_we = !(s && w);
    e_re = !(s && r && !a[3]);
    e_oe = s && w;
    if (s && w) e_d = d;
    e_ce = !ce;
  endtask

  task automatic check_all();
    chk("R1/R2 cle", 16'(card_cle_o), 16'(e_cle));
    chk("R1/R2 ale", 16'(card_ale_o), 16'(e_ale));
    chk("R3 ce", 16'(card_ce_no), 16'(e_ce));
    chk("R4 we", 16'(card_we_no), 16'(e_we));
    chk("R5 re", 16'(card_re_no), 16'(e_re));
    chk("R6 oe", 16'(card_d_oe_o), 16'(e_oe));
    if (e_oe) chk("R6 data", 16'(card_d_o), 16'(e_d));
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_ni = 1'b0;
    sel_i = 0; rd_i = 0; wr_i = 0; addr_i = '0; wdata_i = '0; ce_en_i = 0;
    enforce_i = 0; card_d_i = '0; card_rb_i = 0; card_present_i = 0; card_wp_sense_i = 0;
    prev_sel = 0; e_cle = 0; e_ale = 0; e_we = 1; e_re = 1; e_oe = 0; e_ce = 1; e_d = '0;
    repeat (3) @(negedge clk_i);

    // reset state
    chk("R2 reset cle", 16'(card_cle_o), 16'd0);
    chk("R2 reset ale", 16'(card_ale_o), 16'd0);
    chk("R3 reset ce", 16'(card_ce_no), 16'd1);
    chk("R4 reset we", 16'(card_we_no), 16'd1);
    chk("R5 reset re", 16'(card_re_no), 16'd1);
    chk("R6 reset oe", 16'(card_d_oe_o), 16'd0);
    chk("R8 reset status", 16'(status_o), 16'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // command write at offset 4: cle=1
    drive(1, 0, 1, 3'b010, 8'hA5, 1);
    @(negedge clk_i);
    check_all();
    chk("R1 cle at start", 16'(card_cle_o), 16'd1);
    chk("R6 data A5", 16'(card_d_o), 16'h00A5);
    // offset changes mid access: latches must hold
    drive(1, 0, 1, 3'b001, 8'h3C, 1);
    @(negedge clk_i);
    check_all();
    chk("R2 hold cle mid", 16'(card_cle_o), 16'd1);
    chk("R2 hold ale mid", 16'(card_ale_o), 16'd0);
    drive(0, 0, 0, 3'b001, 8'h00, 1);
    @(negedge clk_i);
    check_all();
    chk("R2 hold idle", 16'(card_cle_o), 16'd1);
    // new access at offset 2: ale=1
    drive(1, 0, 1, 3'b001, 8'h11, 1);
    @(negedge clk_i);
    check_all();
    chk("R1 ale at start", 16'(card_ale_o), 16'd1);
    drive(0, 0, 0, 3'b000, 8'h00, 1);
    @(negedge clk_i);
    check_all();

    // read mask boundary: offset 8 blocked, offset 7 allowed
    drive(1, 1, 0, 3'b100, 8'h00, 1);
    @(negedge clk_i);
    check_all();
    chk("R5 offset8 blocked", 16'(card_re_no), 16'd1);
    drive(1, 1, 0, 3'b011, 8'h00, 1);
    @(negedge clk_i);
    check_all();
    chk("R5 offset7 allowed", 16'(card_re_no), 16'd0);
    chk("R6 read keeps input", 16'(card_d_oe_o), 16'd0);
    drive(0, 0, 0, 3'b000, 8'h00, 0);
    @(negedge clk_i);
    check_all();
    chk("R3 ce standby", 16'(card_ce_no), 16'd1);

    // random accesses
    for (int i = 0; i < 400; i++) begin
      logic s, r, w;
      logic [1:0] op;
      s  = ($urandom_range(2) != 0);
      op = 2'($urandom_range(2));
      r  = (op == 2'd1);
      w  = (op == 2'd2);
      drive(s, r, w, 3'($urandom), 8'($urandom), 1'($urandom));
      @(negedge clk_i);
      check_all();
    end
    drive(0, 0, 0, 3'b000, 8'h00, 0);
    @(negedge clk_i);

    // read data path
    for (int i = 0; i < 8; i++) begin
      logic [7:0] v;
      v = 8'($urandom);
      card_d_i = v;
      #1;
      chk("R7 rdata", rdata_o, {v, 8'h00});
    end

    // status and write-protect mux
    for (int i = 0; i < 24; i++) begin
      logic rb, pr, wp, en;
      rb = 1'($urandom); pr = 1'($urandom); wp = 1'($urandom); en = 1'($urandom);
      if (i == 0) begin rb = 1; pr = 1; wp = 0; en = 1; end
      if (i == 1) begin rb = 0; pr = 0; wp = 0; en = 0; end
      card_rb_i = rb; card_present_i = pr; card_wp_sense_i = wp; enforce_i = en;
      repeat (3) @(negedge clk_i);
      chk("R8 status", 16'(status_o), 16'({wp, pr, rb, 5'b00000}));
      chk("R9 wp pin", 16'(card_wp_no), 16'(en ? wp : 1'b1));
    end

    finish_run();
  end
endmodule